// File: doc/BRIEF.md
# MDIO Management Master with Single Command Register

This block lets a host reach the management registers of an Ethernet PHY through one register. The host writes a PHY address, a register address, a read/write select and, for writes, 16 bits of data. It also sets a start bit. The block then runs a complete clause-22 management frame on the MDC/MDIO pins. While the frame runs, the start bit reads back as 1. Hardware clears the start bit when the frame ends.

A read returns the PHY's 16 data bits in the same field that supplies write data. That field holds valid data once the start bit reads 0. MDC is the system clock divided down by a parameter. MDIO is driven after MDC falls and is sampled when MDC rises. Between frames, MDC rests low and the MDIO driver is off.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `cmd_o` reads 0x020_0000: the PHY address is 1 and every other field is 0. `mdc_o` and `mdio_oe_o` are low.
- R2: The command register layout is as follows. Bits 15:0 hold data, bits 20:16 the register address and bits 25:21 the PHY address. Bit 26 selects the operation (1 = read, 0 = write) and bit 27 is start. A write while start is 0 loads all 28 bits from `wr_data_i`.
- R3: Frame header bits, in order, sampled on MDC rising edges: 32 ones, then 0 1, then opcode 1 0 for a read or 0 1 for a write, then the 5-bit PHY address and the 5-bit register address, each MSB first.
- R4: A write frame follows the header with turnaround 1 0 and then data bits 15:0, MSB first. `mdio_oe_o` stays high for all 64 bits.
- R5: A read frame releases `mdio_oe_o` for bits 46 to 63. It samples `mdio_i` on the MDC rising edges of bits 48 to 63, MSB first, and places the result in data bits 15:0 when the frame completes.
- R6: One MDC period is 2*HALF_DIV system clocks. `mdio_o` changes during a frame only on the system cycle in which MDC falls.
- R7: Start reads 1 for the whole frame and returns to 0 by hardware. This happens after exactly 64 MDC rising edges.
- R8: Host writes while start is 1 are ignored. No field of `cmd_o` changes until hardware clears start.
- R9: After each frame, `mdio_oe_o` is low and `mdc_o` rests low.
- R10: A write frame leaves the data field holding the value that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe for the command register |
| wr_data_i | input | 28 | Host write value |
| cmd_o | output | 28 | Command register readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Write frames are checked with two address/data pairs. One has mixed bits. The other has every address bit set and data 0x0001, so a swapped field or a shift that is off by one shows up at the frame edges. Read frames are checked with the PHY returning 0x1234, 0xFFFF and 0x0000. These separate correct MSB-first capture from a capture that is shifted or stuck, and from leftover write data showing through. One read receives a host write partway through the frame, which checks that the register stays unchanged while start is 1. Every frame is also checked for its length, its MDC period and the idle state of the pins afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W     = 28;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;  // 64
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = FRAME_LEN - DATA_W - 2;                 // 46
  localparam int DATA_POS  = FRAME_LEN - DATA_W;                     // 48
  localparam logic [ADDR_W-1:0] PHY_RST = 5'd1;

  typedef struct packed {
    logic              go;
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_LEN-1:0] frm;
  logic [BIT_W-1:0]     bit_q;
  logic [DATA_W-1:0]    shreg_q;
  logic                 last_bit;

  assign frm = {{PRE_LEN{1'b1}}, 2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i,
                (rd_i ? 2'b00 : 2'b10), (rd_i ? {DATA_W{1'b0}} : wdata_i)};

  assign last_bit = (bit_q == BIT_W'(FRAME_LEN - 1));
  assign mdio_o   = frm[BIT_W'(FRAME_LEN - 1) - bit_q];
  // read frames hand the line to the PHY from turnaround onward
  assign oe_o     = run_i && !(rd_i && (bit_q >= BIT_W'(TA_POS)));
  assign done_o   = run_i && fall_i && last_bit;
  assign rdata_o  = shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
    end else if (!run_i) begin
      bit_q <= '0;
    end else if (fall_i) begin
      bit_q <= last_bit ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else if (run_i && rise_i && rd_i && (bit_q >= BIT_W'(DATA_POS))) begin
      shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CMD_W-1:0] wr_data_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  mdio_cmd_t         cmd_q;
  logic              rise, fall, done;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '{go: 1'b0, rd: 1'b0, phy: PHY_RST, regad: '0, data: '0};
    end else if (done) begin
      cmd_q.go <= 1'b0;
      if (cmd_q.rd) cmd_q.data <= rdata;
    end else if (wr_en_i && !cmd_q.go) begin
      cmd_q <= mdio_cmd_t'(wr_data_i);
    end
  end

  assign cmd_o = cmd_q;

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (cmd_q.go),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (cmd_q.go),
    .rd_i    (cmd_q.rd),
    .phy_i   (cmd_q.phy),
    .reg_i   (cmd_q.regad),
    .wdata_i (cmd_q.data),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk
  import mdio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_go_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o
);
  logic busy;
  assign busy = cmd_o[CMD_W-1];

  assert_idle_pins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));

  assert_mdio_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && busy && !$fell(mdc_o)) |-> $stable(mdio_o));

  assert_frozen_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && busy) |-> $stable(cmd_o));

  assert_start_from_host_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(wr_en_i) && $past(wr_go_i)));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_go_i   (wr_data_i[27]),
  .cmd_o     (cmd_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_cmd_master_tb.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb;
  localparam int HALF = 2;
  localparam int PER_NS = 2 * HALF * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [27:0] wr_data = '0;
  logic [27:0] cmd;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [63:0] seen_bits, seen_oe;
  int          rise_cnt = 0;
  int          per_bad = 0;
  time         last_rise = 0;
  logic [15:0] phy_resp = '0;

  always #2 clk = ~clk;

  mdio_cmd_master #(.HALF_DIV(HALF)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .cmd_o     (cmd),
    .mdc_o     (mdc),
    .mdio_o    (mdio_out),
    .mdio_oe_o (mdio_oe),
    .mdio_i    (mdio_in)
  );

  // PHY model
  always @(posedge mdc) begin
    if (rise_cnt > 0 && ($time - last_rise) != PER_NS) per_bad++;
    last_rise = $time;
    if (rise_cnt < 64) begin
      seen_bits[63-rise_cnt] = mdio_out;
      seen_oe[63-rise_cnt]   = mdio_oe;
    end
    rise_cnt++;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_in = phy_resp[63-rise_cnt];
    else mdio_in = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [27:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [27:0] mk(input bit go, input bit rd, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {go, rd, phy, ra, d};
  endfunction

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!cmd[27]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    check(cmd == 28'h020_0000, "R1 cmd reset", 64'(cmd), 64'h020_0000);
    check(!mdc && !mdio_oe, "R1 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_load();
    host_wr(28'h5A3_1234);
    check(cmd == 28'h5A3_1234, "R2 load idle", 64'(cmd), 64'h5A3_1234);
    check(!mdc && !mdio_oe, "R2 no frame without start", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] exp;
    bit ok;
    rise_cnt = 0; per_bad = 0;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d};
    host_wr(mk(1, 0, phy, ra, d));
    check(cmd[27] == 1'b1, "R7 start held", 64'(cmd[27]), 64'd1);
    wait_idle(ok);
    check(ok, "R7 start clears", 64'(cmd[27]), 64'd0);
    check(rise_cnt == 64, "R7 rise count", 64'(rise_cnt), 64'd64);
    check(seen_bits[63:18] == exp[63:18], "R3 write header", seen_bits, exp);
    check(seen_bits[17:0] == exp[17:0], "R4 write ta+data", seen_bits, exp);
    check(seen_oe == '1, "R4 oe all bits", seen_oe, '1);
    check(per_bad == 0, "R6 mdc period", 64'(per_bad), 64'd0);
    check(cmd == mk(0, 0, phy, ra, d), "R10 data kept", 64'(cmd), 64'(mk(0, 0, phy, ra, d)));
    check(!mdc && !mdio_oe, "R9 idle after write", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] resp,
                        input bit poke);
    logic [63:0] exp;
    logic [27:0] snap;
    bit ok;
    rise_cnt = 0; per_bad = 0;
    phy_resp = resp;
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 18'd0};
    host_wr(mk(1, 1, phy, ra, 16'hDEAD));
    if (poke) begin
      repeat (40) @(negedge clk);
      snap = cmd;
      host_wr(28'h3FF_0F0F);
      check(cmd == snap, "R8 busy write ignored", 64'(cmd), 64'(snap));
    end
    wait_idle(ok);
    check(ok, "R7 start clears read", 64'(cmd[27]), 64'd0);
    check(rise_cnt == 64, "R7 read rise count", 64'(rise_cnt), 64'd64);
    check(seen_bits[63:18] == exp[63:18], "R3 read header", seen_bits, exp);
    check(seen_oe == {{46{1'b1}}, 18'd0}, "R5 oe released", seen_oe, {{46{1'b1}}, 18'd0});
    check(cmd == mk(0, 1, phy, ra, resp), "R5 read data", 64'(cmd), 64'(mk(0, 1, phy, ra, resp)));
    check(per_bad == 0, "R6 read mdc period", 64'(per_bad), 64'd0);
    check(!mdc && !mdio_oe, "R9 idle after read", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load();
    t_write(5'd1, 5'd5, 16'hA55A);
    t_write(5'd31, 5'd31, 16'h0001);
    t_read(5'd3, 5'd2, 16'h1234, 1'b0);
    t_read(5'd1, 5'd17, 16'hFFFF, 1'b1);
    t_read(5'd16, 5'd1, 16'h0000, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule